// File: doc/BRIEF.md
# Test-Sequence Monitor with Lock Hysteresis

This block watches a stream of sample words that a converter sends while in a test mode. It compares every valid word against a locally predicted word from one of four standard maximal-length pseudo-random sequences or a 16-bit counting ramp. The predictor needs no seed input. While the monitor is out of lock it copies each received word into its reference history. Once in lock it runs on its own predictions, so one corrupted word shows up as one mismatch and does not spread to the words after it.

Lock is tracked with uneven hysteresis: a long run of consecutive mismatches drops lock and a shorter run of consecutive matches regains it. Two sticky flags are kept for software. One records that lock was lost. The other records a mismatch seen while locked. Each is cleared by a one-cycle clear strobe. A live lock-loss output is also provided.

Top module: `pnm_monitor`

## Requirements
- R1: After reset `oosLive` and `oosFlag` are 1 and `errFlag` is 0.
- R2: Each sample carries 16 consecutive sequence bits, earliest bit in bit 15. `seqSel` 4'h4 selects x^7+x^6+1, 4'h5 selects x^15+x^14+1, 4'h6 selects x^23+x^18+1 and 4'h7 selects x^31+x^28+1. In each case bit b[n] equals the XOR of the two earlier bits named by the non-constant terms.
- R3: While out of lock the reference is reloaded from each valid received word. `oosLive` falls at the clock edge of the 16th consecutive matching valid sample.
- R4: While in lock, `oosLive` rises at the clock edge of the 64th consecutive mismatching valid sample. Any matching sample restarts that run.
- R5: `errFlag` sets on a valid mismatch while in lock and stays set until `clrErr`. A set in the same cycle as `clrErr` wins. The flag is held at 0 whenever `oosLive` is 1.
- R6: `oosFlag` is 1 in every cycle in which `oosLive` is 1. A `clrOos` strobe clears it only when lock is held.
- R7: `seqSel` 4'hB selects a ramp in which each sample equals the previous sample plus one, modulo 2^16.
- R8: A change of `seqSel` forces `oosLive` to 1 at the next clock edge and restarts both runs.
- R9: Any other `seqSel` code never matches, so the monitor stays out of lock.
- R10: Cycles with `sampleValid` low change neither the reference, the runs nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | Qualifies `sampleData` |
| sampleData | input | 16 | Received test word |
| seqSel | input | 4 | Sequence select code |
| clrOos | input | 1 | Clear strobe for `oosFlag` |
| clrErr | input | 1 | Clear strobe for `errFlag` |
| oosLive | output | 1 | Current out-of-lock state |
| oosFlag | output | 1 | Sticky out-of-lock record |
| errFlag | output | 1 | Sticky in-lock mismatch record |

## Verification
Two kinds of event can land in the same cycle. In the first, a clear strobe for a sticky flag arrives together with the event that sets that flag. The bench drives `clrErr` high with a corrupted in-lock sample and expects `errFlag` to stay 1. It pulses `clrOos` while lock is absent and expects `oosFlag` to stay 1. In the second, the 64th mismatch both records an error and drops lock. The bench sends exactly 63 corrupted words, then one clean word, then 64 more corrupted words. It expects lock to hold through the first run and to drop only on the final word, with `errFlag` reading 0 from that edge on.

// File: rtl/pnm_pkg.sv
package pnm_pkg;

  typedef enum logic [3:0] {
    SEL_PN7  = 4'h4,
    SEL_PN15 = 4'h5,
    SEL_PN23 = 4'h6,
    SEL_PN31 = 4'h7,
    SEL_RAMP = 4'hB
  } seqSel_e;

  // decoded sequence configuration
  typedef struct packed {
    logic       known;
    logic       isRamp;
    logic [4:0] tapHi;   // history index of the older tap
    logic [4:0] tapLo;   // history index of the newer tap
  } seqCfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic advance;   // shift a word into the reference history
    logic takeRecv;  // shift the received word instead of the prediction
  } pnmStrobe_t;

  function automatic seqCfg_t decodeSel(input logic [3:0] code);
    seqCfg_t c;
    c = '{known: 1'b1, isRamp: 1'b0, tapHi: 5'd0, tapLo: 5'd0};
    case (code)
      SEL_PN7:  begin c.tapHi = 5'd6;  c.tapLo = 5'd5;  end
      SEL_PN15: begin c.tapHi = 5'd14; c.tapLo = 5'd13; end
      SEL_PN23: begin c.tapHi = 5'd22; c.tapLo = 5'd17; end
      SEL_PN31: begin c.tapHi = 5'd30; c.tapLo = 5'd27; end
      SEL_RAMP: c.isRamp = 1'b1;
      default:  c.known = 1'b0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/pnm_datapath.sv
module pnm_datapath
  import pnm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TAP_SPAN = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] sampleData,
  input  logic [3:0]        seqSel,
  input  pnmStrobe_t        strb,
  output logic              match
);

  localparam int HIST_W = DATA_W + TAP_SPAN;

  logic [HIST_W-1:0] refHist;
  logic [DATA_W-1:0] expWord;
  seqCfg_t           cfg;

  function automatic logic [DATA_W-1:0] pnWord(input logic [HIST_W-1:0] h0,
                                               input logic [4:0] tA,
                                               input logic [4:0] tB);
    logic [HIST_W-1:0] h;
    logic [DATA_W-1:0] w;
    logic              b;
    h = h0;
    w = '0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      b    = h[tA] ^ h[tB];
      w[i] = b;
      h    = {h[HIST_W-2:0], b};
    end
    return w;
  endfunction

  always_comb begin
    cfg = decodeSel(seqSel);
    if (cfg.isRamp) expWord = refHist[DATA_W-1:0] + DATA_W'(1);
    else            expWord = pnWord(refHist, cfg.tapHi, cfg.tapLo);
    match = cfg.known && (sampleData == expWord);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refHist <= '0;
    end else if (strb.advance) begin
      refHist <= {refHist[HIST_W-DATA_W-1:0], strb.takeRecv ? sampleData : expWord};
    end
  end

  // R3
  seed_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.advance && strb.takeRecv) |-> refHist[DATA_W-1:0] == $past(sampleData));

  // R10
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(!sampleValid) |-> $stable(refHist));

endmodule

// File: rtl/pnm_control.sv
module pnm_control
  import pnm_pkg::*;
#(
  parameter int ENTER_CNT = 64,
  parameter int EXIT_CNT = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleValid,
  input  logic [3:0] seqSel,
  input  logic       match,
  input  logic       clrOos,
  input  logic       clrErr,
  output pnmStrobe_t strb,
  output logic       oosLive,
  output logic       oosFlag,
  output logic       errFlag
);

  localparam int MISS_W = $clog2(ENTER_CNT);
  localparam int HIT_W  = $clog2(EXIT_CNT);

  logic              oosQ, oosNext;
  logic [HIT_W-1:0]  hitCnt, hitNext;
  logic [MISS_W-1:0] missCnt, missNext;
  logic [3:0]        selQ;
  logic              selChange, errSet;
  logic              oosFlagQ, errFlagQ;

  assign selChange     = (seqSel != selQ);
  assign strb.advance  = sampleValid;
  assign strb.takeRecv = oosQ | selChange;
  assign errSet        = sampleValid && !oosQ && !match;

  always_comb begin
    oosNext  = oosQ;
    hitNext  = hitCnt;
    missNext = missCnt;
    if (selChange) begin
      oosNext  = 1'b1;
      hitNext  = '0;
      missNext = '0;
    end else if (sampleValid) begin
      if (oosQ) begin
        if (!match) begin
          hitNext = '0;
        end else if (hitCnt == HIT_W'(EXIT_CNT - 1)) begin
          oosNext = 1'b0;
          hitNext = '0;
        end else begin
          hitNext = hitCnt + HIT_W'(1);
        end
      end else begin
        if (match) begin
          missNext = '0;
        end else if (missCnt == MISS_W'(ENTER_CNT - 1)) begin
          oosNext  = 1'b1;
          missNext = '0;
        end else begin
          missNext = missCnt + MISS_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      oosQ     <= 1'b1;
      hitCnt   <= '0;
      missCnt  <= '0;
      selQ     <= '0;
      oosFlagQ <= 1'b1;
      errFlagQ <= 1'b0;
    end else begin
      oosQ     <= oosNext;
      hitCnt   <= hitNext;
      missCnt  <= missNext;
      selQ     <= seqSel;
      oosFlagQ <= oosNext | (oosFlagQ & ~clrOos);
      errFlagQ <= oosNext ? 1'b0 : (errSet | (errFlagQ & ~clrErr));
    end
  end

  assign oosLive = oosQ;
  assign oosFlag = oosFlagQ;
  assign errFlag = errFlagQ;

  // R3
  oos_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(oosQ) |-> $past(sampleValid && match && hitCnt == HIT_W'(EXIT_CNT - 1)));

  // R4
  oos_enter_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(oosQ) |-> $past(selChange || (sampleValid && !match && missCnt == MISS_W'(ENTER_CNT - 1))));

  // R5
  err_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlagQ) |-> $past(sampleValid && !match && !oosQ));

  // R5
  err_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    oosQ |-> !errFlagQ);

  // R6
  oos_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    oosQ |-> oosFlagQ);

  // R8
  sel_force_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(selChange) |-> oosQ);

endmodule

// File: rtl/pnm_monitor.sv
module pnm_monitor
  import pnm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ENTER_CNT = 64,
  parameter int EXIT_CNT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] sampleData,
  input  logic [3:0]        seqSel,
  input  logic              clrOos,
  input  logic              clrErr,
  output logic              oosLive,
  output logic              oosFlag,
  output logic              errFlag
);

  pnmStrobe_t strb;
  logic       match;

  pnm_datapath #(.DATA_W(DATA_W), .TAP_SPAN(32)) uData (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleData(sampleData),
    .seqSel(seqSel), .strb(strb), .match(match)
  );

  pnm_control #(.ENTER_CNT(ENTER_CNT), .EXIT_CNT(EXIT_CNT)) uCtrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .seqSel(seqSel),
    .match(match), .clrOos(clrOos), .clrErr(clrErr), .strb(strb),
    .oosLive(oosLive), .oosFlag(oosFlag), .errFlag(errFlag)
  );

endmodule

// File: tb/tb_pnm_monitor.sv
`timescale 1ns/1ps
module tb_pnm_monitor;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic [15:0] sampleData = '0;
  logic [3:0]  seqSel = 4'h0;
  logic        clrOos = 1'b0;
  logic        clrErr = 1'b0;
  logic        oosLive, oosFlag, errFlag;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [47:0] gh;
  int gA, gB;

  always #4 clk = ~clk;

  pnm_monitor dut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleData(sampleData),
    .seqSel(seqSel), .clrOos(clrOos), .clrErr(clrErr),
    .oosLive(oosLive), .oosFlag(oosFlag), .errFlag(errFlag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // next 16 sequence bits, earliest in bit 15 (R2)
  function automatic logic [15:0] genWord();
    logic [15:0] w;
    logic b;
    w = '0;
    for (int i = 15; i >= 0; i--) begin
      b = gh[gA] ^ gh[gB];
      w[i] = b;
      gh = {gh[46:0], b};
    end
    return w;
  endfunction

  task automatic push(input logic [15:0] w, input logic cErr);
    sampleValid = 1'b1;
    sampleData = w;
    clrErr = cErr;
    @(negedge clk);
    sampleValid = 1'b0;
    clrErr = 1'b0;
  endtask

  task automatic setSel(input logic [3:0] code);
    seqSel = code;
    @(negedge clk);
  endtask

  task automatic pulseOos();
    clrOos = 1'b1;
    @(negedge clk);
    clrOos = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    logic [15:0] w;
    logic [15:0] r;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 oosLive", oosLive, 1);
    check("R1 oosFlag", oosFlag, 1);
    check("R1 errFlag", errFlag, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 R3 lock on each pseudo-random code
    for (int code = 4; code <= 7; code++) begin
      setSel(code[3:0]);
      case (code)
        4: begin gA = 6;  gB = 5;  end
        5: begin gA = 14; gB = 13; end
        6: begin gA = 22; gB = 17; end
        default: begin gA = 30; gB = 27; end
      endcase
      gh = '1;
      check("R8 oos on select", oosLive, 1);
      for (int i = 0; i < 16; i++) push(genWord(), 0);
      check("R3 still out after 15 matches", oosLive, 1);
      // R6 clear ignored while out of lock
      pulseOos();
      check("R6 oosFlag held while live", oosFlag, 1);
      push(genWord(), 0);
      if (code >= 6) push(genWord(), 0);
      check("R2 R3 lock acquired", oosLive, 0);
      check("R5 no error on lock", errFlag, 0);
    end

    // R6 clear after lock
    pulseOos();
    check("R6 oosFlag cleared", oosFlag, 0);

    // R10 idle cycles with junk data
    sampleData = 16'hDEAD;
    repeat (5) @(negedge clk);
    push(genWord(), 0);
    check("R10 idle ignored oos", oosLive, 0);
    check("R10 idle ignored err", errFlag, 0);

    // R5 single corrupted word in lock
    push(genWord() ^ 16'h0100, 0);
    check("R5 error set", errFlag, 1);
    check("R5 lock kept", oosLive, 0);
    for (int i = 0; i < 4; i++) push(genWord(), 0);
    check("R5 error sticky", errFlag, 1);
    clrErr = 1'b1;
    @(negedge clk);
    clrErr = 1'b0;
    check("R5 error cleared", errFlag, 0);
    push(genWord(), 0);
    check("R5 no spread after corruption", errFlag, 0);
    // R5 set and clear in the same cycle
    push(~genWord(), 1);
    check("R5 set wins over clear", errFlag, 1);

    // R4 hysteresis on the way out
    for (int i = 0; i < 62; i++) push(~genWord(), 0);
    check("R4 63 mismatches keep lock", oosLive, 0);
    push(genWord(), 0);
    for (int i = 0; i < 63; i++) push(~genWord(), 0);
    check("R4 run restarted by match", oosLive, 0);
    check("R6 oosFlag clear in lock", oosFlag, 0);
    push(~genWord(), 0);
    check("R4 64th mismatch drops lock", oosLive, 1);
    check("R5 error forced clear", errFlag, 0);
    check("R6 oosFlag set", oosFlag, 1);

    // R7 ramp with wrap
    setSel(4'hB);
    r = 16'hFFF0;
    for (int i = 0; i < 16; i++) begin push(r, 0); r = r + 16'd1; end
    check("R7 ramp still out", oosLive, 1);
    push(r, 0);
    r = r + 16'd1;
    check("R7 ramp locked across wrap", oosLive, 0);
    push(r + 16'd5, 0);
    r = r + 16'd1;
    check("R7 ramp jump flagged", errFlag, 1);
    push(r, 0);
    check("R7 ramp continues", oosLive, 0);

    // R8 select change drops lock
    setSel(4'h4);
    check("R8 select change", oosLive, 1);
    check("R8 err cleared", errFlag, 0);

    // R9 unknown code never locks
    setSel(4'h2);
    r = 16'h0100;
    for (int i = 0; i < 40; i++) begin push(r, 0); r = r + 16'd1; end
    check("R9 unknown code stays out", oosLive, 1);
    w = 16'h0;
    for (int i = 0; i < 20; i++) push(w, 0);
    check("R9 zeros still out", oosLive, 1);

    finishRun();
  end

endmodule